// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps the time of day and a calendar in seven packed-BCD registers: seconds, minutes, hours, day of month, weekday, month and a two-digit year that covers 2000 to 2099. A single-cycle pulse on the 1 Hz tick input advances the seconds. Each carry then ripples upward, one field per clock cycle, through a small carry sequencer. The host loads and reads every register through a byte-wide port with a combinational read path. A control register selects 12-hour or 24-hour hours format and can stop the count. Bit 7 of the seconds register is a sticky flag that marks the time as untrustworthy after an oscillator fault.

The carry sequencer has six states. In `ST_IDLE` it waits for a tick. A tick that is accepted while the stop bit is clear steps the seconds. If the seconds were at 59, the sequencer moves to `ST_MIN`, otherwise it stays in `ST_IDLE`. `ST_MIN` steps the minutes and moves to `ST_HOUR` on a wrap from 59, otherwise back to `ST_IDLE`. `ST_HOUR` steps the hours and moves to `ST_DAY` on the midnight wrap, otherwise back to `ST_IDLE`. `ST_DAY` steps the date and the weekday and moves to `ST_MONTH` when the date was the last day of the month, otherwise back to `ST_IDLE`. `ST_MONTH` steps the month and moves to `ST_YEAR` on a wrap from 12, otherwise back to `ST_IDLE`. `ST_YEAR` steps the year and always returns to `ST_IDLE`. Ticks are accepted only in `ST_IDLE`; the longest carry lasts six cycles.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the registers read: control 0x00, seconds 0x80, minutes 0x00, hours 0x00, date 0x01, weekday 0x00, month 0x01, year 0x00.
- R2: Each accepted tick adds one to the BCD seconds. 0x59 becomes 0x00 and carries into the minutes.
- R3: Minutes count 0x00 to 0x59. The wrap from 0x59 to 0x00 carries into the hours.
- R4: In 24-hour mode (control bit 3 clear) hours count 0x00 to 0x23. The wrap from 0x23 to 0x00 carries into the date and the weekday.
- R5: In 12-hour mode (control bit 3 set) hours bit 5 is PM and bits 4:0 hold BCD 1 to 12. The hour runs 12, 01 to 11. Going from 11 to 12 toggles PM. The step from 11 PM (0x31) to 12 AM (0x12) carries into the date.
- R6: The date runs from 0x01 to the month's last day: 30 for months 4, 6, 9 and 11; 31 for the other months; 28 for February, or 29 when the year is divisible by 4. The step past the last day returns to 0x01 and carries into the month.
- R7: Month 0x12 wraps to 0x01 and carries into the year. The year counts 0x00 to 0x99 in BCD and wraps to 0x00.
- R8: The weekday counts 0 to 6 and wraps to 0, advancing once at each midnight.
- R9: Seconds bit 7 is the integrity flag. Reset sets it, and so does a pulse on osc_fail. A write to seconds loads bit 7 from the data, so writing 0 clears it. osc_fail wins in the same cycle.
- R10: While control bit 5 (stop) is set, ticks are ignored and the time does not change.
- R11: The address map is control 0x00, then seconds, minutes, hours, date, weekday, month and year at 0x03 to 0x09. Unused register bits read 0 and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| osc_fail | input | 1 | Oscillator fault pulse, sets the integrity flag |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
A wrong sequencer state or field increment shows at the ports as a bad BCD value or a missed carry. It is visible on the first read after the tick that crosses the affected boundary, so the bench reads back every field within eight cycles of each boundary tick. The checks cover the 59, 23, 11/12, month-end, leap-February and 99 boundaries. A wrong integrity flag or stop decode shows on the very next seconds read.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MONTH,
        ST_YEAR
    } rtcc_state_e;

    localparam int REG_CTRL  = 0;
    localparam int REG_SEC   = 3;
    localparam int REG_MIN   = 4;
    localparam int REG_HOUR  = 5;
    localparam int REG_DATE  = 6;
    localparam int REG_WDAY  = 7;
    localparam int REG_MONTH = 8;
    localparam int REG_YEAR  = 9;

    localparam int CTRL_MODE12_BIT = 3;
    localparam int CTRL_STOP_BIT   = 5;

    localparam int SEC_W   = 7;
    localparam int MIN_W   = 7;
    localparam int HOUR_W  = 6;
    localparam int DATE_W  = 6;
    localparam int WDAY_W  = 3;
    localparam int MONTH_W = 5;
    localparam int YEAR_W  = 8;

endpackage

// File: rtl/rtcc_bcd_step.sv
module rtcc_bcd_step #(
    parameter int W     = 8,
    parameter int FIRST = 0
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] last,
    output logic [W-1:0] nxt,
    output logic         at_last
);
    logic [7:0] c8;
    logic [7:0] n8;

    always_comb begin
        c8      = 8'(cur);
        at_last = (cur == last);
        if (at_last) begin
            n8 = 8'(FIRST);
        end else if (c8[3:0] >= 4'h9) begin
            n8 = {c8[7:4] + 4'd1, 4'h0};
        end else begin
            n8 = {c8[7:4], c8[3:0] + 4'd1};
        end
        nxt = W'(n8);
    end
endmodule

// File: rtl/rtcc_hour_step.sv
module rtcc_hour_step (
    input  logic [5:0] cur,
    input  logic       mode12,
    output logic [5:0] nxt,
    output logic       day_wrap
);
    logic       pm;
    logic [4:0] h12;
    logic [4:0] inc12;
    logic [5:0] inc24;

    always_comb begin
        pm  = cur[5];
        h12 = cur[4:0];
        if (h12[3:0] == 4'h9) inc12 = {1'b1, 4'h0};
        else                  inc12 = {h12[4], h12[3:0] + 4'd1};
        if (cur[3:0] == 4'h9) inc24 = {cur[5:4] + 2'd1, 4'h0};
        else                  inc24 = {cur[5:4], cur[3:0] + 4'd1};

        day_wrap = 1'b0;
        if (mode12) begin
            if (h12 == 5'h12) begin
                nxt = {pm, 5'h01};
            end else if (h12 == 5'h11) begin
                nxt      = {~pm, 5'h12};
                day_wrap = pm;
            end else begin
                nxt = {pm, inc12};
            end
        end else begin
            if (cur == 6'h23) begin
                nxt      = 6'h00;
                day_wrap = 1'b1;
            end else begin
                nxt = inc24;
            end
        end
    end
endmodule

// File: rtl/rtcc_month_len.sv
module rtcc_month_len (
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [5:0] last_date
);
    logic [6:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
        leap     = (year_bin[1:0] == 2'b00);
        case (month)
            5'h02:                      last_date = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
            default:                    last_date = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtcc_seq_fsm.sv
module rtcc_seq_fsm
    import rtcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        stop,
    input  logic        sec_last,
    input  logic        min_last,
    input  logic        hour_wrap,
    input  logic        date_last,
    input  logic        month_last,
    output rtcc_state_e state,
    output logic        step_sec,
    output logic        step_min,
    output logic        step_hour,
    output logic        step_day,
    output logic        step_month,
    output logic        step_year
);
    rtcc_state_e state_q;
    rtcc_state_e state_d;
    logic        accept;

    assign accept = tick && !stop;
    assign state  = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = (accept && sec_last) ? ST_MIN : ST_IDLE;
            ST_MIN:   state_d = min_last   ? ST_HOUR  : ST_IDLE;
            ST_HOUR:  state_d = hour_wrap  ? ST_DAY   : ST_IDLE;
            ST_DAY:   state_d = date_last  ? ST_MONTH : ST_IDLE;
            ST_MONTH: state_d = month_last ? ST_YEAR  : ST_IDLE;
            ST_YEAR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        step_sec   = 1'b0;
        step_min   = 1'b0;
        step_hour  = 1'b0;
        step_day   = 1'b0;
        step_month = 1'b0;
        step_year  = 1'b0;
        unique case (state_q)
            ST_IDLE:  step_sec   = accept;
            ST_MIN:   step_min   = 1'b1;
            ST_HOUR:  step_hour  = 1'b1;
            ST_DAY:   step_day   = 1'b1;
            ST_MONTH: step_month = 1'b1;
            ST_YEAR:  step_year  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtcc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              osc_fail,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(REG_SEC);
    localparam logic [ADDR_W-1:0] A_MIN   = ADDR_W'(REG_MIN);
    localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(REG_HOUR);
    localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(REG_DATE);
    localparam logic [ADDR_W-1:0] A_WDAY  = ADDR_W'(REG_WDAY);
    localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(REG_MONTH);
    localparam logic [ADDR_W-1:0] A_YEAR  = ADDR_W'(REG_YEAR);

    logic               ctrl_mode12;
    logic               ctrl_stop;
    logic               osc_bad;
    logic [SEC_W-1:0]   sec_q;
    logic [MIN_W-1:0]   min_q;
    logic [HOUR_W-1:0]  hour_q;
    logic [DATE_W-1:0]  date_q;
    logic [WDAY_W-1:0]  wday_q;
    logic [MONTH_W-1:0] month_q;
    logic [YEAR_W-1:0]  year_q;

    logic [SEC_W-1:0]   sec_nxt;
    logic [MIN_W-1:0]   min_nxt;
    logic [HOUR_W-1:0]  hour_nxt;
    logic [DATE_W-1:0]  date_nxt;
    logic [WDAY_W-1:0]  wday_nxt;
    logic [MONTH_W-1:0] month_nxt;
    logic [YEAR_W-1:0]  year_nxt;
    logic [DATE_W-1:0]  date_last_val;

    logic sec_last, min_last, hour_wrap, date_last, month_last;
    logic year_last, wday_last;
    logic step_sec, step_min, step_hour, step_day, step_month, step_year;
    rtcc_state_e fsm_state;

    logic wr_ctrl, wr_sec, wr_min, wr_hour, wr_date, wr_wday, wr_month, wr_year;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_sec   = bus_wr && (bus_addr == A_SEC);
    assign wr_min   = bus_wr && (bus_addr == A_MIN);
    assign wr_hour  = bus_wr && (bus_addr == A_HOUR);
    assign wr_date  = bus_wr && (bus_addr == A_DATE);
    assign wr_wday  = bus_wr && (bus_addr == A_WDAY);
    assign wr_month = bus_wr && (bus_addr == A_MONTH);
    assign wr_year  = bus_wr && (bus_addr == A_YEAR);

    rtcc_bcd_step #(.W(SEC_W), .FIRST(0)) u_sec_step (
        .cur(sec_q), .last(SEC_W'(8'h59)), .nxt(sec_nxt), .at_last(sec_last)
    );
    rtcc_bcd_step #(.W(MIN_W), .FIRST(0)) u_min_step (
        .cur(min_q), .last(MIN_W'(8'h59)), .nxt(min_nxt), .at_last(min_last)
    );
    rtcc_hour_step u_hour_step (
        .cur(hour_q), .mode12(ctrl_mode12), .nxt(hour_nxt), .day_wrap(hour_wrap)
    );
    rtcc_month_len u_month_len (
        .month(month_q), .year(year_q), .last_date(date_last_val)
    );
    rtcc_bcd_step #(.W(DATE_W), .FIRST(1)) u_date_step (
        .cur(date_q), .last(date_last_val), .nxt(date_nxt), .at_last(date_last)
    );
    rtcc_bcd_step #(.W(WDAY_W), .FIRST(0)) u_wday_step (
        .cur(wday_q), .last(WDAY_W'(6)), .nxt(wday_nxt), .at_last(wday_last)
    );
    rtcc_bcd_step #(.W(MONTH_W), .FIRST(1)) u_month_step (
        .cur(month_q), .last(MONTH_W'(8'h12)), .nxt(month_nxt), .at_last(month_last)
    );
    rtcc_bcd_step #(.W(YEAR_W), .FIRST(0)) u_year_step (
        .cur(year_q), .last(YEAR_W'(8'h99)), .nxt(year_nxt), .at_last(year_last)
    );

    rtcc_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .stop(ctrl_stop),
        .sec_last(sec_last), .min_last(min_last), .hour_wrap(hour_wrap),
        .date_last(date_last), .month_last(month_last),
        .state(fsm_state),
        .step_sec(step_sec), .step_min(step_min), .step_hour(step_hour),
        .step_day(step_day), .step_month(step_month), .step_year(step_year)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_mode12 <= 1'b0;
            ctrl_stop   <= 1'b0;
            osc_bad     <= 1'b1;
            sec_q       <= '0;
            min_q       <= '0;
            hour_q      <= '0;
            date_q      <= DATE_W'(1);
            wday_q      <= '0;
            month_q     <= MONTH_W'(1);
            year_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_mode12 <= bus_wdata[CTRL_MODE12_BIT];
                ctrl_stop   <= bus_wdata[CTRL_STOP_BIT];
            end
            if (wr_sec) begin
                sec_q   <= bus_wdata[SEC_W-1:0];
                osc_bad <= bus_wdata[7];
            end else if (step_sec) begin
                sec_q <= sec_nxt;
            end
            if (osc_fail) osc_bad <= 1'b1;
            if (wr_min)        min_q <= bus_wdata[MIN_W-1:0];
            else if (step_min) min_q <= min_nxt;
            if (wr_hour)        hour_q <= bus_wdata[HOUR_W-1:0];
            else if (step_hour) hour_q <= hour_nxt;
            if (wr_date)       date_q <= bus_wdata[DATE_W-1:0];
            else if (step_day) date_q <= date_nxt;
            if (wr_wday)       wday_q <= bus_wdata[WDAY_W-1:0];
            else if (step_day) wday_q <= wday_nxt;
            if (wr_month)        month_q <= bus_wdata[MONTH_W-1:0];
            else if (step_month) month_q <= month_nxt;
            if (wr_year)        year_q <= bus_wdata[YEAR_W-1:0];
            else if (step_year) year_q <= year_nxt;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTRL_MODE12_BIT] = ctrl_mode12;
                bus_rdata[CTRL_STOP_BIT]   = ctrl_stop;
            end
            A_SEC:   bus_rdata = {osc_bad, sec_q};
            A_MIN:   bus_rdata = 8'(min_q);
            A_HOUR:  bus_rdata = 8'(hour_q);
            A_DATE:  bus_rdata = 8'(date_q);
            A_WDAY:  bus_rdata = 8'(wday_q);
            A_MONTH: bus_rdata = 8'(month_q);
            A_YEAR:  bus_rdata = year_q;
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker
    import rtcc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1hz,
    input logic        osc_fail,
    input logic        bus_wr,
    input logic        ctrl_stop,
    input logic        ctrl_mode12,
    input logic        osc_bad,
    input rtcc_state_e fsm_state,
    input logic [6:0]  sec_q,
    input logic [5:0]  hour_q,
    input logic [4:0]  month_q
);
    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && tick_1hz && !ctrl_stop && sec_q == 7'h59 && !bus_wr)
        |=> (sec_q == 7'h00 && fsm_state == ST_MIN));

    assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HOUR && !ctrl_mode12 && hour_q == 6'h23 && !bus_wr)
        |=> (hour_q == 6'h00 && fsm_state == ST_DAY));

    assert_pm_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HOUR && ctrl_mode12 && hour_q[4:0] == 5'h11 && !bus_wr)
        |=> (hour_q[5] != $past(hour_q[5]) && hour_q[4:0] == 5'h12));

    assert_month_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_MONTH && month_q == 5'h12 && !bus_wr)
        |=> (month_q == 5'h01 && fsm_state == ST_YEAR));

    assert_osc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail |=> osc_bad);

    assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_stop && fsm_state == ST_IDLE && !bus_wr) |=> $stable(sec_q));
endmodule

bind rtc_bcd_calendar rtcc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_fail(osc_fail),
    .bus_wr(bus_wr), .ctrl_stop(ctrl_stop), .ctrl_mode12(ctrl_mode12),
    .osc_bad(osc_bad), .fsm_state(fsm_state), .sec_q(sec_q),
    .hour_q(hour_q), .month_q(month_q)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       osc_fail = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    int         n_tests = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    rtc_bcd_calendar #(.ADDR_W(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_fail(osc_fail),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic [4:0] addr;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    event chk_ev;

    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%02h actual=%02h expected=%02h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic expect_reg(input logic [4:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        #1;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->chk_ev;
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_1hz = 1'b1;
            @(negedge clk);
            tick_1hz = 1'b0;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dt, input logic [7:0] wd,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(5'h03, s); wr(5'h04, m); wr(5'h05, h); wr(5'h06, dt);
        wr(5'h07, wd); wr(5'h08, mo); wr(5'h09, yr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R9 flag set by reset
        expect_reg(5'h00, 8'h00, "R1 ctrl");
        expect_reg(5'h03, 8'h80, "R1 R9 sec flag");
        expect_reg(5'h04, 8'h00, "R1 min");
        expect_reg(5'h05, 8'h00, "R1 hour");
        expect_reg(5'h06, 8'h01, "R1 date");
        expect_reg(5'h07, 8'h00, "R1 wday");
        expect_reg(5'h08, 8'h01, "R1 month");
        expect_reg(5'h09, 8'h00, "R1 year");

        // R9 clear flag by writing seconds
        wr(5'h03, 8'h00);
        expect_reg(5'h03, 8'h00, "R9 clear");

        // R2 plain counting with BCD digit carry
        wr(5'h03, 8'h08);
        ticks(3);
        expect_reg(5'h03, 8'h11, "R2 bcd count");

        // R2 R3 R4 R6 R8 full carry, non-leap February
        set_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h06, 8'h02, 8'h23);
        ticks(1);
        expect_reg(5'h03, 8'h59, "R2 sec 59");
        expect_reg(5'h04, 8'h59, "R3 min held");
        ticks(1);
        expect_reg(5'h03, 8'h00, "R2 sec wrap");
        expect_reg(5'h04, 8'h00, "R3 min wrap");
        expect_reg(5'h05, 8'h00, "R4 hour wrap");
        expect_reg(5'h06, 8'h01, "R6 feb28 nonleap");
        expect_reg(5'h08, 8'h03, "R6 month after feb");
        expect_reg(5'h07, 8'h00, "R8 wday wrap");
        expect_reg(5'h09, 8'h23, "R7 year held");

        // R6 leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h24);
        ticks(1);
        expect_reg(5'h06, 8'h29, "R6 leap feb29");
        expect_reg(5'h08, 8'h02, "R6 leap month held");
        expect_reg(5'h07, 8'h03, "R8 wday step");
        set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h03, 8'h02, 8'h24);
        ticks(1);
        expect_reg(5'h06, 8'h01, "R6 leap feb29 wrap");
        expect_reg(5'h08, 8'h03, "R6 leap month step");

        // R6 30 and 31 day months
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h04, 8'h24);
        ticks(1);
        expect_reg(5'h06, 8'h01, "R6 apr30 wrap");
        expect_reg(5'h08, 8'h05, "R6 may");
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h01, 8'h24);
        ticks(1);
        expect_reg(5'h06, 8'h31, "R6 jan31");
        expect_reg(5'h08, 8'h01, "R6 jan held");

        // R7 year rollovers
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h05, 8'h12, 8'h99);
        ticks(1);
        expect_reg(5'h09, 8'h00, "R7 year 99 wrap");
        expect_reg(5'h08, 8'h01, "R7 month wrap");
        expect_reg(5'h06, 8'h01, "R7 date wrap");
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h05, 8'h12, 8'h19);
        ticks(1);
        expect_reg(5'h09, 8'h20, "R7 year bcd carry");

        // R5 12-hour mode
        wr(5'h00, 8'h08);
        expect_reg(5'h00, 8'h08, "R11 R5 ctrl mode");
        set_time(8'h59, 8'h59, 8'h11, 8'h10, 8'h01, 8'h05, 8'h24);
        ticks(1);
        expect_reg(5'h05, 8'h32, "R5 11am to 12pm");
        expect_reg(5'h06, 8'h10, "R5 no day carry at noon");
        wr(5'h04, 8'h59); wr(5'h03, 8'h59);
        ticks(1);
        expect_reg(5'h05, 8'h21, "R5 12pm to 1pm");
        wr(5'h05, 8'h09); wr(5'h04, 8'h59); wr(5'h03, 8'h59);
        ticks(1);
        expect_reg(5'h05, 8'h10, "R5 9 to 10");
        wr(5'h05, 8'h31); wr(5'h04, 8'h59); wr(5'h03, 8'h59);
        ticks(1);
        expect_reg(5'h05, 8'h12, "R5 11pm to 12am");
        expect_reg(5'h06, 8'h11, "R5 day carry");
        expect_reg(5'h07, 8'h02, "R8 midnight 12h");

        // R10 stop
        wr(5'h00, 8'h20);
        wr(5'h03, 8'h10);
        ticks(2);
        expect_reg(5'h03, 8'h10, "R10 stopped");
        wr(5'h00, 8'h00);
        ticks(1);
        expect_reg(5'h03, 8'h11, "R10 resumed");

        // R9 osc_fail pulse
        @(negedge clk); osc_fail = 1'b1;
        @(negedge clk); osc_fail = 1'b0;
        expect_reg(5'h03, 8'h91, "R9 osc_fail sets flag");
        wr(5'h03, 8'h45);
        expect_reg(5'h03, 8'h45, "R9 write clears");

        // R11 masking and unmapped addresses
        wr(5'h00, 8'hFF);
        expect_reg(5'h00, 8'h28, "R11 ctrl mask");
        wr(5'h00, 8'h00);
        wr(5'h04, 8'hFF);
        expect_reg(5'h04, 8'h7F, "R11 min mask");
        wr(5'h08, 8'hFF);
        expect_reg(5'h08, 8'h1F, "R11 month mask");
        expect_reg(5'h01, 8'h00, "R11 unmapped 1");
        expect_reg(5'h0A, 8'h00, "R11 unmapped 10");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule